// File: doc/BRIEF.md
# Speaker Load Diagnostic Sequencer

This controller runs connection tests on the outputs of a four-channel bridge amplifier. A host raises a one-cycle start request. The request is taken only while the sequencer is idle and at least one channel reports that its output stage is in the high-impedance state. An accepted run opens a channel-synchronization window. It then steps through timed test phases, one after another, with a one-hot select that tells the analog sensing circuitry which test to apply. A settle window follows the last phase, and the run ends with a done pulse. Every window length is counted in pulses of a millisecond tick, so a simulation can set the windows short through parameters.

The run takes one of two levels, fixed when the start is accepted. If every channel is in high impedance, the full level runs four tests on all channels together: short to ground, short to supply, open load, and shorted load. If only some channels are in high impedance, the reduced level runs the two short tests, and results are kept only for the channels that were in high impedance at the start. On the last tick of each phase, the sensing circuitry's per-channel comparator flag is stored into that channel's status word. The host reads a status word by selecting the channel on a read port.

Top module: `load_diag_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, done, sync_win, settle_win and phase_sel are all 0, and every channel's status word reads 0.
- R2: A start request is refused when hiz_ch is all zero. busy stays low, no window or phase opens, and the status words keep their values.
- R3: When hiz_ch is all ones at the accepted start, full_level reads 1 and the phases run in this order: phase_sel bit 0 (short to ground), bit 1 (short to supply), bit 2 (open load), bit 3 (shorted load). At most one bit of phase_sel is high at a time.
- R4: When hiz_ch is nonzero but not all ones at the accepted start, full_level reads 0. Only phase_sel bits 0 and 1 are used, and status bits are kept only for the channels whose hiz_ch bit was set at the start. Later changes to hiz_ch do not alter the run.
- R5: The sync window lasts SYNC_TICKS ticks, each phase lasts PHASE_TICKS ticks, and the settle window lasts SETTLE_TICKS ticks. Cycles without ms_tick do not advance the sequence.
- R6: Status bit p of channel c takes the value of diag_flag[c] in the cycle of the last tick of phase p. Bit 0 holds the short-to-ground result, bit 1 short to supply, bit 2 open load, and bit 3 shorted load. Flag values on earlier ticks of the phase are ignored.
- R7: Every status bit is cleared when a start is accepted.
- R8: Start requests that arrive while busy is high are ignored. The level, the channel mask and the timing all stay as they were.
- R9: busy is high from the cycle after an accepted start until the settle window ends. done is a one-cycle pulse in the first cycle busy is low again.
- R10: rd_status shows the status word of the channel selected by rd_ch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond tick pulse |
| start_req | input | 1 | Start request from the control register |
| hiz_ch | input | NUM_CH | Per-channel high-impedance status |
| diag_flag | input | NUM_CH | Per-channel comparator result for the selected test |
| rd_ch | input | SEL_W | Channel selected for status read |
| rd_status | output | 4 | Status word of the selected channel |
| phase_sel | output | 4 | One-hot test select to the sensing circuitry |
| sync_win | output | 1 | Channel-synchronization window active |
| settle_win | output | 1 | Post-test settle window active |
| busy | output | 1 | Diagnostic run in progress |
| full_level | output | 1 | Level of the current or last run (1 = full) |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest situation to bring about is a state change that arrives in the middle of a run. This covers a second start request, or a change of hiz_ch, while the sequencer is busy. It also covers comparator flags that change inside a phase, where only the last tick may count. The bench sweeps every nonzero high-impedance mask. During each run it raises a new start with all channels in high impedance, and on every tick except the last of each phase it drives the inverse of the expected flag pattern. A wrong mask, a wrong level or an early capture therefore shows up directly in the read-back status words. An all-zero mask is tried after a run, to check that a refused start leaves the earlier results in place.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;

    localparam int unsigned NUM_TESTS = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_TEST   = 2'd2,
        ST_SETTLE = 2'd3
    } seq_state_e;

    // test index equals the status bit position it fills
    typedef enum logic [1:0] {
        T_GND   = 2'd0,
        T_SUP   = 2'd1,
        T_OPEN  = 2'd2,
        T_SHORT = 2'd3
    } test_e;

    function automatic logic [NUM_TESTS-1:0] test_onehot(input test_e t);
        logic [NUM_TESTS-1:0] v;
        v = '0;
        v[t] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/diag_tick_timer.sv
module diag_tick_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && !restart && ((cnt_q + CNT_W'(1)) == limit);
        cnt_d  = cnt_q;
        if (restart || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/diag_result_bank.sv
module diag_result_bank
    import diag_seq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 capture,
    input  test_e                test_idx,
    input  logic [NUM_CH-1:0]    flags,
    input  logic [NUM_CH-1:0]    mask,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [NUM_TESTS-1:0] rd_word
);

    logic [NUM_TESTS-1:0] word_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_TESTS-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (clear) begin
                row_d = '0;
            end else if (capture) begin
                row_d[test_idx] = flags[c] & mask[c];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign word_q[c] = row_q;
    end

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_sel == SEL_W'(c)) begin
                rd_word = word_q[c];
            end
        end
    end

endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
    import diag_seq_pkg::*;
#(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned SYNC_TICKS   = 100,
    parameter int unsigned PHASE_TICKS  = 50,
    parameter int unsigned SETTLE_TICKS = 150,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ms_tick,
    input  logic                 start_req,
    input  logic [NUM_CH-1:0]    hiz_ch,
    input  logic [NUM_CH-1:0]    diag_flag,
    input  logic [SEL_W-1:0]     rd_ch,
    output logic [NUM_TESTS-1:0] rd_status,
    output logic [NUM_TESTS-1:0] phase_sel,
    output logic                 sync_win,
    output logic                 settle_win,
    output logic                 busy,
    output logic                 full_level,
    output logic                 done
);

    localparam int unsigned MAX_A = (SYNC_TICKS > PHASE_TICKS) ? SYNC_TICKS : PHASE_TICKS;
    localparam int unsigned MAX_T = (MAX_A > SETTLE_TICKS) ? MAX_A : SETTLE_TICKS;
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_state_e        state;
        test_e             test;
        logic [NUM_CH-1:0] mask;
        logic              full;
        logic              done;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             start_ok;
    logic             tmr_restart;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic             res_clear;
    logic             res_capture;
    test_e            last_test;

    diag_tick_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (ms_tick),
        .limit   (tmr_limit),
        .expire  (tmr_expire)
    );

    diag_result_bank #(.NUM_CH(NUM_CH)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (res_clear),
        .capture  (res_capture),
        .test_idx (r_q.test),
        .flags    (diag_flag),
        .mask     (r_q.mask),
        .rd_sel   (rd_ch),
        .rd_word  (rd_status)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        res_clear   = 1'b0;
        res_capture = 1'b0;
        tmr_restart = 1'b0;
        start_ok    = start_req && (r_q.state == ST_IDLE) && (|hiz_ch);
        last_test   = r_q.full ? T_SHORT : T_SUP;

        case (r_q.state)
            ST_SYNC:   tmr_limit = CNT_W'(SYNC_TICKS);
            ST_TEST:   tmr_limit = CNT_W'(PHASE_TICKS);
            ST_SETTLE: tmr_limit = CNT_W'(SETTLE_TICKS);
            default:   tmr_limit = CNT_W'(1);
        endcase

        case (r_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d.state   = ST_SYNC;
                    r_d.test    = T_GND;
                    r_d.mask    = hiz_ch;
                    r_d.full    = &hiz_ch;
                    res_clear   = 1'b1;
                    tmr_restart = 1'b1;
                end
            end
            ST_SYNC: begin
                if (tmr_expire) begin
                    r_d.state = ST_TEST;
                end
            end
            ST_TEST: begin
                if (tmr_expire) begin
                    res_capture = 1'b1;
                    if (r_q.test == last_test) begin
                        r_d.state = ST_SETTLE;
                    end else begin
                        r_d.test = test_e'(r_q.test + 2'd1);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expire) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, test: T_GND, mask: '0, full: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign sync_win   = (r_q.state == ST_SYNC);
    assign settle_win = (r_q.state == ST_SETTLE);
    assign phase_sel  = (r_q.state == ST_TEST) ? test_onehot(r_q.test) : '0;
    assign full_level = r_q.full;
    assign done       = r_q.done;

endmodule

// File: rtl/load_diag_seq_chk.sv
module load_diag_seq_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic [NUM_CH-1:0] hiz_ch,
    input logic [3:0]        phase_sel,
    input logic              sync_win,
    input logic              settle_win,
    input logic              busy,
    input logic              full_level,
    input logic              done
);

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_sel));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (phase_sel == 4'b0 && !sync_win && !settle_win));

    assert_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && hiz_ch == '0) |=> !busy);

    assert_order_sup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel[1]) |-> $past(phase_sel[0]));

    assert_order_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel[2]) |-> $past(phase_sel[1]));

    assert_order_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel[3]) |-> $past(phase_sel[2]));

    assert_reduced_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !full_level) |-> (phase_sel[3:2] == 2'b00));

    assert_sync_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel[0]) |-> $past(sync_win));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> $stable(full_level));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind load_diag_seq load_diag_seq_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .hiz_ch     (hiz_ch),
    .phase_sel  (phase_sel),
    .sync_win   (sync_win),
    .settle_win (settle_win),
    .busy       (busy),
    .full_level (full_level),
    .done       (done)
);

// File: tb/load_diag_seq_tb_top.sv
`timescale 1ns/1ps
module load_diag_seq_tb_top;

    localparam int S = 3;
    localparam int P = 2;
    localparam int E = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       start_req = 1'b0;
    logic [3:0] hiz_ch = 4'h0;
    logic [3:0] diag_flag = 4'h0;
    logic [1:0] rd_ch = 2'd0;
    logic [3:0] rd_status;
    logic [3:0] phase_sel;
    logic       sync_win;
    logic       settle_win;
    logic       busy;
    logic       full_level;
    logic       done;

    int n_vec = 0;
    int n_fail = 0;
    logic [3:0] exp_stat [4];

    always #2.5 clk = ~clk;

    load_diag_seq #(
        .NUM_CH(4), .SYNC_TICKS(S), .PHASE_TICKS(P), .SETTLE_TICKS(E)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start_req(start_req),
        .hiz_ch(hiz_ch), .diag_flag(diag_flag), .rd_ch(rd_ch),
        .rd_status(rd_status), .phase_sel(phase_sel), .sync_win(sync_win),
        .settle_win(settle_win), .busy(busy), .full_level(full_level), .done(done)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] patt(input int h, input int p);
        return 4'((h * 5 + p * 3 + 1) & 15);
    endfunction

    task automatic check_status(input string tag);
        for (int c = 0; c < 4; c++) begin
            rd_ch = 2'(c);
            #1;
            chk({4'h0, rd_status}, {4'h0, exp_stat[c]}, tag);
        end
    endtask

    task automatic run(input int h);
        bit full;
        int np, total;
        logic [3:0] exp_sel;
        full  = (h == 15);
        np    = full ? 4 : 2;
        total = S + np * P + E;
        hiz_ch = 4'(h);
        start_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        chk({7'h0, busy}, 8'h1, "R9 busy after start");
        chk({7'h0, full_level}, {7'h0, full}, full ? "R3 full level" : "R4 reduced level");
        for (int c = 0; c < 4; c++) exp_stat[c] = 4'h0;
        check_status("R7 cleared at start");
        for (int n = 0; n < total; n++) begin
            exp_sel = 4'h0;
            if (n >= S && n < S + np * P) exp_sel = 4'(1 << ((n - S) / P));
            chk({4'h0, phase_sel}, {4'h0, exp_sel}, "R5 phase timing R3 order");
            chk({7'h0, busy}, 8'h1, "R9 busy during run");
            diag_flag = ~patt(h, 0);
            for (int p = 0; p < np; p++) begin
                if (n >= S + p * P && n < S + (p + 1) * P) diag_flag = ~patt(h, p);
                if (n == S + (p + 1) * P - 1) diag_flag = patt(h, p);
            end
            if (n == S + 1) begin
                start_req = 1'b1;
                hiz_ch = 4'hF;
            end
            ms_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ms_tick = 1'b0;
            start_req = 1'b0;
            hiz_ch = 4'(h);
            if (n < total - 1) begin
                diag_flag = ~diag_flag;
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk({7'h0, done}, 8'h1, "R9 done pulse");
        chk({7'h0, busy}, 8'h0, "R9 busy cleared");
        @(posedge clk);
        @(negedge clk);
        chk({7'h0, done}, 8'h0, "R9 done one cycle");
        for (int c = 0; c < 4; c++) begin
            exp_stat[c] = 4'h0;
            for (int p = 0; p < np; p++)
                exp_stat[c][p] = h[c] & patt(h, p)[c];
        end
        check_status(full ? "R6 R10 full results" : "R4 R6 R8 reduced results");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) exp_stat[c] = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk({7'h0, busy}, 8'h0, "R1 busy");
        chk({7'h0, done}, 8'h0, "R1 done");
        chk({4'h0, phase_sel}, 8'h0, "R1 phase_sel");
        chk({6'h0, sync_win, settle_win}, 8'h0, "R1 windows");
        check_status("R1 status");
        for (int h = 1; h < 16; h++) run(h);
        start_req = 1'b1;
        hiz_ch = 4'h0;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk({7'h0, busy}, 8'h0, "R2 refused busy");
            chk({4'h0, phase_sel}, 8'h0, "R2 refused phase");
            ms_tick = (k % 2) == 0;
            @(posedge clk);
            @(negedge clk);
        end
        ms_tick = 1'b0;
        check_status("R2 status kept");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule